// File: doc/BRIEF.md
# Linked-Descriptor Buffer Streaming Engine

This engine walks a chain of buffer descriptors held in a word-addressed memory. Each buffer is played out as a stream of 32-bit beats. Every descriptor takes four consecutive memory words. The engine reads the descriptor, then reads each word of the buffer it names and presents that word on a valid/ready output stream. When the buffer is finished, the engine either follows the link to the next descriptor, holds until software tells it to go on, or parks at the end of the list.

Software drives the engine through a three-entry register write port: a control word, a descriptor pointer and a command word. It watches the `busy`, `done` and `irq` outputs. A list that has parked can be extended in place. Software edits the parked descriptor and issues a continue command, and the engine then reads that same descriptor again and acts on its new contents.

Top module: `dma_list_walker`

## Requirements
- R1: After reset, `busy`, `done`, `irq`, `out_valid` and `mem_req` are all low. The control word resets to disabled and not stopped.
- R2: Descriptor layout, at word offsets from the descriptor address: +0 is the link to the next descriptor, +1 is the first buffer address, +2 is the flag word, +3 is the buffer end address. The engine reads these four words in order, and only one unit reads memory at a time. A read issued in one cycle returns `mem_rdata` in the next cycle.
- R3: A descriptor yields one beat for each address a with start ≤ a < end, in ascending order, and `out_data` is the memory word at a. If end ≤ start, the descriptor yields no beats.
- R4: `out_last` is high only on the final beat of a buffer whose flag bit 3 is set. Flag bit 11 and the unused flag bits have no effect. `out_meta` carries flag bits 31:16 on every beat of that buffer.
- R5: `irq` is a one-cycle pulse, raised once for each finished descriptor whose flag bit 4 is set. This includes descriptors with empty buffers.
- R6: When flag bit 0 (end of list) is clear, the engine fetches the linked descriptor. When it is set, the engine parks with `done` high and issues no further reads or beats.
- R7: When flag bit 5 (hold) is set and bit 0 is clear, the engine holds after the buffer with `busy` and `done` both low. It issues no reads or beats until a continue command arrives, and then it follows the link.
- R8: A continue command while parked fetches the parked descriptor again from the same address and processes its current contents.
- R9: `busy` is high while a descriptor is being fetched or transferred. Any command written while `busy` is high is discarded. A continue command is discarded unless the engine is parked or holding.
- R10: While the stop bit is set, no new memory read is issued and no new beat starts. Clearing the bit resumes the stream with no beat lost or repeated.
- R11: Clearing the enable bit returns the engine to idle on the next cycle, with `busy`, `out_valid` and `mem_req` low. Commands written while the engine is disabled are discarded.
- R12: Register select values: 0 is the control word (bit 0 enable, bit 1 stop), 1 is the descriptor pointer, 2 is the command word. Command bits 1:0 take the value 1 for load, which fetches the descriptor at the pointer, and 2 for continue.
- R13: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_last` and `out_meta` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| busy | output | 1 | Fetch or transfer in progress |
| done | output | 1 | Parked at end of list |
| irq | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory word address |
| mem_rdata | input | 32 | Read data, one cycle after request |
| out_valid | output | 1 | Stream beat valid |
| out_ready | input | 1 | Stream sink ready |
| out_data | output | 32 | Stream beat data |
| out_last | output | 1 | End-of-packet marker |
| out_meta | output | 16 | Metadata of the current buffer |

## Verification
The hardest case to reach from the ports is the in-place extension of a parked list. Software has to rewrite the end-of-list descriptor after the engine has read it and before the continue command, so that the second fetch sees different contents at the same address. The bench edits its memory model only after `done` is seen high. It then issues the continue command and checks that the stream matches the edited contents followed by the newly linked descriptor. Stop and disable are applied in the middle of long buffers, and a command is written at a point where `busy` is known to be high. Random ready gaps keep beats stalled at the output.

// File: rtl/dlw_pkg.sv
package dlw_pkg;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_PTR  = 2'd1;
  localparam logic [1:0] SEL_CMD  = 2'd2;

  localparam logic [1:0] OP_LOAD  = 2'd1;
  localparam logic [1:0] OP_CONT  = 2'd2;

  localparam int FB_EOL  = 0;
  localparam int FB_EOP  = 3;
  localparam int FB_IRQ  = 4;
  localparam int FB_HOLD = 5;

  localparam int DESC_WORDS = 4;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_FETCH, SQ_XFER, SQ_HOLD, SQ_PARK
  } seq_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_ISSUE, ST_WAIT, ST_SEND
  } strm_e;

  typedef struct packed {
    logic [31:0] link;
    logic [31:0] first;
    logic [31:0] flags;
    logic [31:0] limit;
  } desc_t;

  // number of beats a buffer produces: end is exclusive
  function automatic logic [31:0] span_beats(logic [31:0] first, logic [31:0] limit);
    return (limit > first) ? (limit - first) : 32'd0;
  endfunction

  // true when addr is the last address inside the buffer
  function automatic logic final_beat(logic [31:0] addr, logic [31:0] limit);
    return ({1'b0, addr} + 33'd1) >= {1'b0, limit};
  endfunction

endpackage

// File: rtl/dlw_regs.sv
module dlw_regs
  import dlw_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [1:0]    sel,
  input  logic [31:0]   wdata,
  input  logic          busy,
  output logic          en,
  output logic          stop,
  output logic [AW-1:0] ptr,
  output logic          load_req,
  output logic          cont_req
);

  logic cmd_wr;
  logic unused_wbits;

  assign cmd_wr       = wr && (sel == SEL_CMD) && en && !busy;
  assign load_req     = cmd_wr && (wdata[1:0] == OP_LOAD);
  assign cont_req     = cmd_wr && (wdata[1:0] == OP_CONT);
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= 1'b0;
      stop <= 1'b0;
      ptr  <= '0;
    end else if (wr) begin
      case (sel)
        SEL_CTRL: begin
          en   <= wdata[0];
          stop <= wdata[1];
        end
        SEL_PTR: ptr <= wdata[AW-1:0];
        default: ;
      endcase
    end
  end

  p_cfg_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_CTRL) |=> (en == $past(wdata[0]) && stop == $past(wdata[1])));

endmodule

// File: rtl/dlw_fetch.sv
module dlw_fetch
  import dlw_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic          stall,
  input  logic [31:0]   mem_rdata,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic          done,
  output desc_t         desc
);

  localparam int IW = $clog2(DESC_WORDS) + 1;
  localparam int CW = $clog2(DESC_WORDS);

  logic          active;
  logic [IW-1:0] issue;
  logic [CW-1:0] cap;
  logic          rd_q;
  logic [AW-1:0] base_q;
  logic [31:0]   wds [DESC_WORDS];

  assign rd_req  = active && (issue < IW'(DESC_WORDS)) && !stall;
  assign rd_addr = base_q + AW'(issue);
  assign desc    = '{link: wds[0], first: wds[1], flags: wds[2], limit: wds[3]};

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      active <= 1'b0;
      issue  <= '0;
      cap    <= '0;
      rd_q   <= 1'b0;
      done   <= 1'b0;
      base_q <= '0;
    end else begin
      done <= 1'b0;
      rd_q <= rd_req;
      if (start) begin
        active <= 1'b1;
        issue  <= '0;
        cap    <= '0;
        base_q <= base;
      end else if (active) begin
        if (rd_req) issue <= issue + IW'(1);
        if (rd_q) begin
          cap <= cap + CW'(1);
          if (cap == CW'(DESC_WORDS - 1)) begin
            active <= 1'b0;
            done   <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rd_q && active) wds[cap] <= mem_rdata;
  end

  p_fetch_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> issue < IW'(DESC_WORDS));

endmodule

// File: rtl/dlw_stream.sv
module dlw_stream
  import dlw_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          start,
  input  logic [31:0]   buf_first,
  input  logic [31:0]   buf_limit,
  input  logic          buf_eop,
  input  logic [15:0]   buf_meta,
  input  logic          stall,
  input  logic [31:0]   mem_rdata,
  input  logic          out_ready,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic          out_valid,
  output logic [31:0]   out_data,
  output logic          out_last,
  output logic [15:0]   out_meta,
  output logic          done
);

  strm_e       st;
  logic [31:0] addr;
  logic [31:0] limit;
  logic        eop;
  logic        is_final;

  assign rd_req   = (st == ST_ISSUE) && !stall;
  assign rd_addr  = addr[AW-1:0];
  assign is_final = final_beat(addr, limit);

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      st        <= ST_IDLE;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
      out_meta  <= '0;
      done      <= 1'b0;
      addr      <= '0;
      limit     <= '0;
      eop       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          addr     <= buf_first;
          limit    <= buf_limit;
          eop      <= buf_eop;
          out_meta <= buf_meta;
          if (span_beats(buf_first, buf_limit) == 32'd0) done <= 1'b1;
          else st <= ST_ISSUE;
        end
        ST_ISSUE: if (!stall) st <= ST_WAIT;
        ST_WAIT: begin
          out_data  <= mem_rdata;
          out_last  <= eop && is_final;
          out_valid <= 1'b1;
          st        <= ST_SEND;
        end
        ST_SEND: if (out_ready) begin
          out_valid <= 1'b0;
          out_last  <= 1'b0;
          if (is_final) begin
            done <= 1'b1;
            st   <= ST_IDLE;
          end else begin
            addr <= addr + 32'd1;
            st   <= ST_ISSUE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_addr_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> addr < limit);

  p_hold_beat_r13: assert property (@(posedge clk) disable iff (!rst_n || abort)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last) && $stable(out_meta)));

endmodule

// File: rtl/dma_list_walker.sv
module dma_list_walker
  import dlw_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic          busy,
  output logic          done,
  output logic          irq,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic [31:0]   mem_rdata,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [31:0]   out_data,
  output logic          out_last,
  output logic [15:0]   out_meta
);

  logic          cfg_en, cfg_stop;
  logic [AW-1:0] cfg_ptr;
  logic          load_req, cont_req, load_ok, cont_ok;
  seq_e          state, nstate;
  logic [AW-1:0] cur_ptr, go_base;
  logic          go_fetch, s_start, irq_set;
  logic          f_rd, f_done, s_rd, s_done;
  logic [AW-1:0] f_addr, s_addr;
  desc_t         f_desc;
  logic          unused_desc;

  assign busy        = (state == SQ_FETCH) || (state == SQ_XFER);
  assign done        = (state == SQ_PARK);
  assign load_ok     = load_req;
  assign cont_ok     = cont_req && ((state == SQ_HOLD) || (state == SQ_PARK));
  assign mem_req     = f_rd || s_rd;
  assign mem_addr    = (state == SQ_FETCH) ? f_addr : s_addr;
  assign unused_desc = ^{f_desc.link, f_desc.flags[15:6], f_desc.flags[2:1]};

  dlw_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .busy(busy), .en(cfg_en), .stop(cfg_stop), .ptr(cfg_ptr),
    .load_req(load_req), .cont_req(cont_req)
  );

  dlw_fetch #(.AW(AW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .abort(!cfg_en), .start(go_fetch), .base(go_base),
    .stall(cfg_stop), .mem_rdata(mem_rdata), .rd_req(f_rd), .rd_addr(f_addr),
    .done(f_done), .desc(f_desc)
  );

  dlw_stream #(.AW(AW)) u_stream (
    .clk(clk), .rst_n(rst_n), .abort(!cfg_en), .start(s_start),
    .buf_first(f_desc.first), .buf_limit(f_desc.limit),
    .buf_eop(f_desc.flags[FB_EOP]), .buf_meta(f_desc.flags[31:16]),
    .stall(cfg_stop), .mem_rdata(mem_rdata), .out_ready(out_ready),
    .rd_req(s_rd), .rd_addr(s_addr), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .out_meta(out_meta), .done(s_done)
  );

  always_comb begin
    nstate   = state;
    go_fetch = 1'b0;
    go_base  = cur_ptr;
    s_start  = 1'b0;
    irq_set  = 1'b0;
    case (state)
      SQ_IDLE: if (load_ok) begin
        go_fetch = 1'b1; go_base = cfg_ptr; nstate = SQ_FETCH;
      end
      SQ_FETCH: if (f_done) begin
        s_start = 1'b1; nstate = SQ_XFER;
      end
      SQ_XFER: if (s_done) begin
        irq_set = f_desc.flags[FB_IRQ];
        if (f_desc.flags[FB_EOL])       nstate = SQ_PARK;
        else if (f_desc.flags[FB_HOLD]) nstate = SQ_HOLD;
        else begin
          go_fetch = 1'b1; go_base = f_desc.link[AW-1:0]; nstate = SQ_FETCH;
        end
      end
      SQ_HOLD: if (load_ok) begin
        go_fetch = 1'b1; go_base = cfg_ptr; nstate = SQ_FETCH;
      end else if (cont_ok) begin
        go_fetch = 1'b1; go_base = f_desc.link[AW-1:0]; nstate = SQ_FETCH;
      end
      SQ_PARK: if (load_ok) begin
        go_fetch = 1'b1; go_base = cfg_ptr; nstate = SQ_FETCH;
      end else if (cont_ok) begin
        go_fetch = 1'b1; go_base = cur_ptr; nstate = SQ_FETCH;
      end
      default: nstate = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !cfg_en) begin
      state   <= SQ_IDLE;
      irq     <= 1'b0;
      if (!rst_n) cur_ptr <= '0;
    end else begin
      state <= nstate;
      irq   <= irq_set;
      if (go_fetch) cur_ptr <= go_base;
    end
  end

  p_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_one_reader_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(f_rd && s_rd));

  p_park_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!out_valid && !mem_req));

  p_hold_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_HOLD) |-> (!out_valid && !mem_req && !busy));

  p_refetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_PARK && cont_ok) |=> (mem_addr == $past(cur_ptr)));

  p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_stop) && $past(cfg_stop, 2)) |-> !$rose(out_valid));

  p_disable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (!busy && !out_valid && !mem_req));

endmodule

// File: tb/tb_dma_list_walker.sv
module tb_dma_list_walker;
  localparam int AW = 16;
  localparam bit [31:0] F_EOL = 32'h1, F_EOP = 32'h8, F_IRQ = 32'h10, F_HOLD = 32'h20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic out_ready = 1'b1;
  logic [31:0] mem_rdata = 32'd0;
  logic busy, done, irq, mem_req, out_valid, out_last;
  logic [AW-1:0] mem_addr;
  logic [31:0] out_data;
  logic [15:0] out_meta;

  bit [31:0] mem [256];
  bit [48:0] got_q[$], exp_q[$];
  int n_chk = 0, n_fail = 0, irq_cnt = 0, exp_irq = 0, cyc = 0;
  bit rnd_ready = 1'b0, prev_stall = 1'b0, wd_fired = 1'b0;
  bit [48:0] prev_beat;

  dma_list_walker #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .busy(busy), .done(done), .irq(irq), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .out_meta(out_meta)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (mem_req) mem_rdata <= mem[mem_addr[7:0]];
  end

  always @(posedge clk) begin
    #1;
    out_ready = rnd_ready ? ($urandom_range(0, 3) != 0) : 1'b1;
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s got=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        chk(out_valid && ({out_last, out_meta, out_data} == prev_beat), "R13",
            "stalled beat changed", {out_last, out_meta, out_data}, prev_beat);
      prev_stall = out_valid && !out_ready;
      prev_beat  = {out_last, out_meta, out_data};
      if (out_valid && out_ready) got_q.push_back({out_last, out_meta, out_data});
      if (irq) irq_cnt++;
    end
    if (cyc > 150000 && !wd_fired) begin
      wd_fired = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog got=%0d exp=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wr_reg(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_quiet();
    int k = 0;
    repeat (2) @(negedge clk);
    while (busy && k < 20000) begin
      @(negedge clk);
      k++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_obs();
    got_q.delete(); exp_q.delete(); irq_cnt = 0; exp_irq = 0;
  endtask

  task automatic put_desc(input int p, input int nx, input int s, input int e, input bit [31:0] f);
    mem[p] = nx; mem[p+1] = s; mem[p+2] = f; mem[p+3] = e;
  endtask

  // expected stream from a chain; stops after end-of-list or hold
  function automatic int walk(input int p0);
    int p = p0;
    for (int n = 0; n < 16; n++) begin
      int s = int'(mem[p+1]);
      int e = int'(mem[p+3]);
      bit [31:0] f = mem[p+2];
      for (int a = s; a < e; a++)
        exp_q.push_back({f[3] && (a == e - 1), f[31:16], mem[a[7:0]]});
      if (f[4]) exp_irq++;
      if (f[0] || f[5]) return p;
      p = int'(mem[p]);
    end
    return p;
  endfunction

  task automatic compare(input string rq);
    chk(got_q.size() == exp_q.size(), rq, "beat count", got_q.size(), exp_q.size());
    for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
      chk(got_q[i] == exp_q[i], rq, $sformatf("beat %0d", i), got_q[i], exp_q[i]);
    chk(irq_cnt == exp_irq, "R5", "irq pulses", irq_cnt, exp_irq);
  endtask

  initial begin
    int nd;
    void'($urandom(32'd715));
    for (int i = 0; i < 256; i++) mem[i] = $urandom;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !irq && !out_valid && !mem_req, "R1", "reset outputs",
        {busy, done, irq, out_valid, mem_req}, 0);

    wr_reg(2'd0, 32'd1);

    // R2 R3 R4 R5 R6 R12: chain with an empty buffer in the middle
    put_desc(32'h10, 32'h14, 32'h40, 32'h44, 32'hABCD0000 | F_EOP | F_IRQ | 32'h800);
    put_desc(32'h14, 32'h18, 32'h50, 32'h50, F_IRQ | F_EOP);
    put_desc(32'h18, 32'h00, 32'h60, 32'h63, 32'h12340000 | F_EOL | F_EOP);
    clear_obs();
    void'(walk(32'h10));
    wr_reg(2'd1, 32'h10);
    wr_reg(2'd2, 32'd1);
    wait_quiet();
    compare("R3");
    chk(done, "R6", "parked after end of list", done, 1);

    // R8: edit parked descriptor in place, then continue
    put_desc(32'h18, 32'h1C, 32'h70, 32'h72, 32'h55550000 | F_EOP);
    put_desc(32'h1C, 32'h00, 32'h80, 32'h81, F_EOL | F_IRQ | F_EOP);
    clear_obs();
    void'(walk(32'h18));
    wr_reg(2'd2, 32'd2);
    wait_quiet();
    compare("R8");
    chk(done, "R8", "parked again", done, 1);

    // R7: hold flag stops after the buffer until continue
    put_desc(32'h24, 32'h28, 32'h90, 32'h92, F_HOLD | F_IRQ);
    put_desc(32'h28, 32'h00, 32'h98, 32'h99, F_EOL | F_EOP);
    clear_obs();
    void'(walk(32'h24));
    wr_reg(2'd1, 32'h24);
    wr_reg(2'd2, 32'd1);
    wait_quiet();
    repeat (10) @(negedge clk);
    compare("R7");
    chk(!busy && !done, "R7", "holding state", {busy, done}, 0);
    void'(walk(32'h28));
    wr_reg(2'd2, 32'd2);
    wait_quiet();
    compare("R7");
    chk(done, "R7", "parked after continue", done, 1);

    // R9: load written while busy is discarded
    put_desc(32'h20, 32'h00, 32'h40, 32'h60, F_EOL | F_EOP);
    rnd_ready = 1'b1;
    clear_obs();
    void'(walk(32'h20));
    wr_reg(2'd1, 32'h20);
    wr_reg(2'd2, 32'd1);
    repeat (10) @(negedge clk);
    chk(busy, "R9", "busy mid transfer", busy, 1);
    wr_reg(2'd1, 32'h1C);
    wr_reg(2'd2, 32'd1);
    wait_quiet();
    compare("R9");
    rnd_ready = 1'b0;

    // R10: stop pauses, resume loses nothing
    put_desc(32'h2C, 32'h00, 32'h40, 32'h58, F_EOL | F_EOP | F_IRQ);
    clear_obs();
    void'(walk(32'h2C));
    wr_reg(2'd1, 32'h2C);
    wr_reg(2'd2, 32'd1);
    repeat (20) @(negedge clk);
    wr_reg(2'd0, 32'd3);
    repeat (4) @(negedge clk);
    nd = got_q.size();
    repeat (40) @(negedge clk);
    chk(got_q.size() == nd, "R10", "beats while stopped", got_q.size(), nd);
    chk(busy, "R10", "busy while stopped", busy, 1);
    wr_reg(2'd0, 32'd1);
    wait_quiet();
    compare("R10");

    // R11: disable mid transfer
    clear_obs();
    wr_reg(2'd2, 32'd1);
    repeat (15) @(negedge clk);
    wr_reg(2'd0, 32'd0);
    @(negedge clk);
    chk(!busy && !out_valid && !mem_req, "R11", "idle after disable",
        {busy, out_valid, mem_req}, 0);
    nd = got_q.size();
    wr_reg(2'd2, 32'd1);
    repeat (20) @(negedge clk);
    chk(got_q.size() == nd && !busy, "R11", "load ignored while disabled", got_q.size(), nd);
    wr_reg(2'd0, 32'd1);
    // R9: continue from idle is discarded
    clear_obs();
    wr_reg(2'd2, 32'd2);
    repeat (10) @(negedge clk);
    chk(!busy && !done && got_q.size() == 0, "R9", "continue in idle",
        {busy, done, 1'b0}, 0);
    void'(walk(32'h2C));
    wr_reg(2'd2, 32'd1);
    wait_quiet();
    compare("R11");

    // R3 R4 R6: random lists with random ready gaps
    rnd_ready = 1'b1;
    for (int r = 0; r < 8; r++) begin
      int n = $urandom_range(1, 4);
      for (int k = 0; k < n; k++) begin
        int s = 32'h40 + $urandom_range(0, 100);
        int e = ($urandom_range(0, 7) == 0) ? s - 2 : s + $urandom_range(0, 6);
        bit [31:0] f = ($urandom & 32'hFFFF0000) | ($urandom_range(0, 1) ? F_EOP : 0)
                     | ($urandom_range(0, 1) ? F_IRQ : 0) | ($urandom_range(0, 1) ? 32'h800 : 0);
        if (k == n - 1) f = f | F_EOL;
        put_desc(32'hC0 + 4 * k, 32'hC4 + 4 * k, s, e, f);
      end
      clear_obs();
      void'(walk(32'hC0));
      wr_reg(2'd1, 32'hC0);
      wr_reg(2'd2, 32'd1);
      wait_quiet();
      compare("R4");
      chk(done, "R6", "random list parked", done, 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule